// File: doc/BRIEF.md
# Byte Access Adapter for Word-Only Memory

This block connects a processor-side port that issues byte addresses to a memory that can only be read or written one full 32-bit word at a time. The memory has no byte enables. The adapter forms the word address by dropping the two low byte-address bits. It also drops any address bits above the memory's range. A small sequencer then runs the memory accesses that each request needs.

A byte load fetches the word that holds the byte and returns that byte in the low 8 bits. The byte is zero-extended, or sign-extended when the request asks for it. A byte store has no byte enable to use, so it becomes a read-modify-write: read the word, clear the target lane with an AND mask, OR in the new byte, and write the whole word back.

Word loads are always allowed. When the low two address bits are not zero, the returned word is rotated by that byte offset. An aligned word store goes straight to memory. A misaligned word store is refused with an error response and does not touch memory.

Both sides use valid/ready handshakes. Only one request is in flight at a time.

Top module: `byte_word_bridge`

## Requirements
- R1: The memory word address equals byte-address bits [MEM_AW+1:2]. Byte-address bits above MEM_AW+1 have no effect. The memory request, address and data stay steady while the memory holds ready low.
- R2: An unsigned byte load (cpuReqByte=1, cpuReqSigned=0) returns the byte in lane `off = addr[1:0]` in bits 7:0, with bits 31:8 set to zero. Lanes are little-endian: off 0 is word bits 7:0 and off 3 is word bits 31:24. It uses exactly one memory read and no memory write.
- R3: A signed byte load (cpuReqSigned=1) returns the same byte, with bits 31:8 all copies of its bit 7.
- R4: A byte store runs exactly one memory read followed by exactly one memory write. The written word equals the word read, with only lane `off` replaced by cpuReqWdata[7:0].
- R5: An aligned word store (cpuReqByte=0, off=0) makes exactly one memory write of cpuReqWdata and no read.
- R6: A word load makes exactly one memory read. It returns the word rotated right by 8*off bits, so result lane k is memory lane (k+off) mod 4. Offset 0 returns the word unchanged.
- R7: A word store with off not 0 makes no memory access. It answers with cpuRspErr=1 in the cycle after it is accepted.
- R8: cpuReqReady is high only while the adapter is idle. It is low from acceptance until the response has been given, and a memory request is never pending while it is high.
- R9: Each accepted request produces a cpuRspValid pulse exactly one cycle long. cpuRspErr is 0 except in the R7 case. Store responses carry data 0.
- R10: During reset, cpuReqReady=1, cpuRspValid=0 and memReqValid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cpuReqValid | input | 1 | Processor request valid |
| cpuReqReady | output | 1 | Adapter can accept a request |
| cpuReqWrite | input | 1 | 1 = store, 0 = load |
| cpuReqByte | input | 1 | 1 = byte access, 0 = word access |
| cpuReqSigned | input | 1 | Sign-extend a byte load |
| cpuReqAddr | input | ADDR_W | Byte address |
| cpuReqWdata | input | 32 | Store data (byte store uses bits 7:0) |
| cpuRspValid | output | 1 | One-cycle response strobe |
| cpuRspData | output | 32 | Load result, zero for stores |
| cpuRspErr | output | 1 | Misaligned word store refused |
| memReqValid | output | 1 | Memory request valid |
| memReqReady | input | 1 | Memory accepts the request |
| memReqWrite | output | 1 | 1 = word write, 0 = word read |
| memReqAddr | output | MEM_AW | Word address |
| memReqWdata | output | 32 | Word to write |
| memRspValid | input | 1 | Read data valid, at least one cycle after acceptance |
| memRspData | input | 32 | Read word |

## Verification
The bench builds the adapter with ADDR_W=8 and MEM_AW=4: a 16-word memory and two address bits above its range. This small size lets every one of the 64 byte addresses be swept for signed and unsigned byte loads, rotated word loads and byte stores. Each sweep uses a different pattern in the two discarded high bits, so address aliasing is checked on every access. The bench's memory drops ready in an irregular pattern, and it counts its reads and writes per request, so the access sequence of each request type is checked as well as its data.

// File: rtl/bwb_pkg.sv
package bwb_pkg;
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned LANE_W     = 8;
  localparam int unsigned WORD_W     = WORD_BYTES * LANE_W;
  localparam int unsigned OFF_W      = $clog2(WORD_BYTES);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_WAIT,
    ST_MERGE,
    ST_WR_WAIT,
    ST_RESP
  } seqState_t;

  typedef struct packed {
    logic capReq;   // latch the processor request
    logic capWord;  // latch the word returned by memory
    logic doMerge;  // fold the store byte into the latched word
  } dpStrobe_t;
endpackage

// File: rtl/bwb_ctrl.sv
module bwb_ctrl
  import bwb_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuReqValid,
  input  logic             cpuReqWrite,
  input  logic             cpuReqByte,
  input  logic [OFF_W-1:0] cpuReqOffset,
  output logic             cpuReqReady,
  output logic             cpuRspValid,
  output logic             cpuRspErr,
  output logic             memReqValid,
  input  logic             memReqReady,
  output logic             memReqWrite,
  input  logic             memRspValid,
  output dpStrobe_t        strobe
);

  seqState_t state, stateNext;
  logic opWrite;
  logic errReg;
  logic reqSent;
  logic badWordStore;
  logic readDone;

  assign badWordStore = cpuReqWrite && !cpuReqByte && (cpuReqOffset != '0);
  assign readDone     = (state == ST_RD_WAIT) && reqSent && memRspValid;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (cpuReqValid) begin
          if (badWordStore)                   stateNext = ST_RESP;
          else if (cpuReqWrite && !cpuReqByte) stateNext = ST_WR_WAIT;
          else                                 stateNext = ST_RD_WAIT;
        end
      end
      ST_RD_WAIT: if (readDone) stateNext = opWrite ? ST_MERGE : ST_RESP;
      ST_MERGE:   stateNext = ST_WR_WAIT;
      ST_WR_WAIT: if (memReqReady) stateNext = ST_RESP;
      ST_RESP:    stateNext = ST_IDLE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      opWrite <= 1'b0;
      errReg  <= 1'b0;
      reqSent <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == ST_IDLE && cpuReqValid) begin
        opWrite <= cpuReqWrite;
        errReg  <= badWordStore;
      end
      if (readDone)
        reqSent <= 1'b0;
      else if (state == ST_RD_WAIT && memReqReady)
        reqSent <= 1'b1;
    end
  end

  assign cpuReqReady = (state == ST_IDLE);
  assign cpuRspValid = (state == ST_RESP);
  assign cpuRspErr   = (state == ST_RESP) && errReg;
  assign memReqValid = ((state == ST_RD_WAIT) && !reqSent) || (state == ST_WR_WAIT);
  assign memReqWrite = (state == ST_WR_WAIT);

  assign strobe.capReq  = (state == ST_IDLE) && cpuReqValid;
  assign strobe.capWord = readDone;
  assign strobe.doMerge = (state == ST_MERGE);

  // R9: the response strobe lasts one cycle and returns to idle
  assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    cpuRspValid |=> (!cpuRspValid && cpuReqReady));

  // R8: no memory traffic or response while accepting requests
  assert_ready_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    cpuReqReady |-> (!memReqValid && !cpuRspValid));

  // R7: a misaligned word store is answered at once with an error and no memory access
  assert_bad_store_err_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReqValid && cpuReqReady && cpuReqWrite && !cpuReqByte && (cpuReqOffset != '0))
      |=> (cpuRspValid && cpuRspErr && !memReqValid));

  // R1: a stalled memory request is held
  assert_mem_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqWrite)));

endmodule

// File: rtl/bwb_datapath.sv
module bwb_datapath
  import bwb_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned MEM_AW = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] cpuReqAddr,
  input  logic [WORD_W-1:0] cpuReqWdata,
  input  logic              cpuReqWrite,
  input  logic              cpuReqByte,
  input  logic              cpuReqSigned,
  input  logic [WORD_W-1:0] memRspData,
  output logic [MEM_AW-1:0] memReqAddr,
  output logic [WORD_W-1:0] memReqWdata,
  output logic [WORD_W-1:0] cpuRspData
);

  localparam int unsigned KEEP_W = MEM_AW + OFF_W;

  logic [KEEP_W-1:0] addrReg;
  logic [WORD_W-1:0] wdataReg;
  logic [WORD_W-1:0] wordReg;
  logic              byteReg, signedReg, writeReg;

  logic [OFF_W-1:0]  offset;
  logic [LANE_W-1:0] laneBytes [WORD_BYTES];
  logic [WORD_W-1:0] rotWord;
  logic [LANE_W-1:0] selByte;
  logic [WORD_W-1:0] byteExt;
  logic [WORD_W-1:0] laneMask;
  logic [WORD_W-1:0] laneIns;
  logic [WORD_W-1:0] mergedWord;
  logic [4:0]        shiftAmt;

  assign offset   = addrReg[OFF_W-1:0];
  assign shiftAmt = {offset, 3'b000};

  for (genvar g = 0; g < WORD_BYTES; g++) begin : gLane
    logic [OFF_W-1:0] srcIdx;
    assign laneBytes[g] = wordReg[g*LANE_W +: LANE_W];
    assign srcIdx = offset + OFF_W'(g);
    assign rotWord[g*LANE_W +: LANE_W] = laneBytes[srcIdx];
  end

  assign selByte = laneBytes[offset];
  assign byteExt = signedReg ? {{(WORD_W-LANE_W){selByte[LANE_W-1]}}, selByte}
                             : {{(WORD_W-LANE_W){1'b0}}, selByte};

  assign laneMask   = ~({{(WORD_W-LANE_W){1'b0}}, {LANE_W{1'b1}}} << shiftAmt);
  assign laneIns    = {{(WORD_W-LANE_W){1'b0}}, wdataReg[LANE_W-1:0]} << shiftAmt;
  assign mergedWord = (wordReg & laneMask) | laneIns;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg   <= '0;
      wdataReg  <= '0;
      wordReg   <= '0;
      byteReg   <= 1'b0;
      signedReg <= 1'b0;
      writeReg  <= 1'b0;
    end else begin
      if (strobe.capReq) begin
        addrReg   <= cpuReqAddr[KEEP_W-1:0];
        wdataReg  <= cpuReqWdata;
        byteReg   <= cpuReqByte;
        signedReg <= cpuReqSigned;
        writeReg  <= cpuReqWrite;
      end
      if (strobe.capWord)
        wordReg <= memRspData;
      else if (strobe.doMerge)
        wordReg <= mergedWord;
    end
  end

  assign memReqAddr  = addrReg[KEEP_W-1:OFF_W];
  assign memReqWdata = byteReg ? wordReg : wdataReg;
  assign cpuRspData  = writeReg ? '0 : (byteReg ? byteExt : rotWord);

  // R4: the merge step only alters the addressed lane
  assert_merge_lane_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doMerge |=> ((wordReg & $past(laneMask)) == ($past(wordReg) & $past(laneMask))));

endmodule

// File: rtl/byte_word_bridge.sv
module byte_word_bridge
  import bwb_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned MEM_AW = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReqValid,
  output logic              cpuReqReady,
  input  logic              cpuReqWrite,
  input  logic              cpuReqByte,
  input  logic              cpuReqSigned,
  input  logic [ADDR_W-1:0] cpuReqAddr,
  input  logic [31:0]       cpuReqWdata,
  output logic              cpuRspValid,
  output logic [31:0]       cpuRspData,
  output logic              cpuRspErr,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic              memReqWrite,
  output logic [MEM_AW-1:0] memReqAddr,
  output logic [31:0]       memReqWdata,
  input  logic              memRspValid,
  input  logic [31:0]       memRspData
);

  dpStrobe_t strobe;

  bwb_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cpuReqValid  (cpuReqValid),
    .cpuReqWrite  (cpuReqWrite),
    .cpuReqByte   (cpuReqByte),
    .cpuReqOffset (cpuReqAddr[OFF_W-1:0]),
    .cpuReqReady  (cpuReqReady),
    .cpuRspValid  (cpuRspValid),
    .cpuRspErr    (cpuRspErr),
    .memReqValid  (memReqValid),
    .memReqReady  (memReqReady),
    .memReqWrite  (memReqWrite),
    .memRspValid  (memRspValid),
    .strobe       (strobe)
  );

  bwb_datapath #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .cpuReqAddr   (cpuReqAddr),
    .cpuReqWdata  (cpuReqWdata),
    .cpuReqWrite  (cpuReqWrite),
    .cpuReqByte   (cpuReqByte),
    .cpuReqSigned (cpuReqSigned),
    .memRspData   (memRspData),
    .memReqAddr   (memReqAddr),
    .memReqWdata  (memReqWdata),
    .cpuRspData   (cpuRspData)
  );

  // R1: address and data of a stalled memory request do not move
  assert_mem_addr_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> ($stable(memReqAddr) && $stable(memReqWdata)));

endmodule

// File: tb/byte_word_bridge_tb_top.sv
`timescale 1ns/1ps
module byte_word_bridge_tb_top;
  localparam int ADDR_W = 8;
  localparam int MEM_AW = 4;
  localparam int WORDS  = 1 << MEM_AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuReqValid = 1'b0, cpuReqWrite = 1'b0, cpuReqByte = 1'b0, cpuReqSigned = 1'b0;
  logic [ADDR_W-1:0] cpuReqAddr = '0;
  logic [31:0] cpuReqWdata = '0;
  logic cpuReqReady, cpuRspValid, cpuRspErr;
  logic [31:0] cpuRspData;
  logic memReqValid, memReqReady, memReqWrite;
  logic [MEM_AW-1:0] memReqAddr;
  logic [31:0] memReqWdata;
  logic memRspValid;
  logic [31:0] memRspData;

  always #10 clk = ~clk;

  byte_word_bridge #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW)) dut_i (
    .clk(clk), .rstN(rstN),
    .cpuReqValid(cpuReqValid), .cpuReqReady(cpuReqReady), .cpuReqWrite(cpuReqWrite),
    .cpuReqByte(cpuReqByte), .cpuReqSigned(cpuReqSigned), .cpuReqAddr(cpuReqAddr),
    .cpuReqWdata(cpuReqWdata), .cpuRspValid(cpuRspValid), .cpuRspData(cpuRspData),
    .cpuRspErr(cpuRspErr), .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqWrite(memReqWrite), .memReqAddr(memReqAddr), .memReqWdata(memReqWdata),
    .memRspValid(memRspValid), .memRspData(memRspData)
  );

  function automatic logic [31:0] initWord(input int i);
    logic [7:0] b0, b1, b2, b3;
    b0 = 8'(i * 37 + 8'h41);
    b1 = 8'(8'hF0 - i * 3);
    b2 = 8'(i * 9 + 5);
    b3 = 8'(i * 16 + 8'h83);
    return {b3, b2, b1, b0};
  endfunction

  // memory model: word-only, irregular ready, read data one cycle after acceptance
  logic [31:0] memArr [WORDS];
  int rdCount, wrCount;
  logic [7:0] readyPat;
  logic pend;
  logic [MEM_AW-1:0] pendAddr;
  assign memReqReady = readyPat[0];

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) memArr[i] <= initWord(i);
      rdCount <= 0; wrCount <= 0;
      readyPat <= 8'b1011_0101;
      pend <= 1'b0; pendAddr <= '0;
      memRspValid <= 1'b0; memRspData <= '0;
    end else begin
      readyPat <= {readyPat[0], readyPat[7:1]};
      memRspValid <= 1'b0;
      if (pend) begin
        memRspValid <= 1'b1;
        memRspData <= memArr[pendAddr];
        pend <= 1'b0;
      end
      if (memReqValid && memReqReady) begin
        if (memReqWrite) begin
          memArr[memReqAddr] <= memReqWdata;
          wrCount <= wrCount + 1;
        end else begin
          pend <= 1'b1;
          pendAddr <= memReqAddr;
          rdCount <= rdCount + 1;
        end
      end
    end
  end

  int checks = 0, errors = 0;
  logic [31:0] refMem [WORDS];
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runReq(input logic wr, input logic byteOp, input logic sgn,
                        input logic [ADDR_W-1:0] addr, input logic [31:0] wd,
                        output logic [31:0] rd, output logic er, output int nRd, output int nWr);
    int r0, w0, n;
    @(negedge clk);
    r0 = rdCount; w0 = wrCount;
    chk(cpuReqReady == 1'b1, "R8 ready when idle", 32'(cpuReqReady), 32'd1);
    cpuReqValid = 1'b1; cpuReqWrite = wr; cpuReqByte = byteOp; cpuReqSigned = sgn;
    cpuReqAddr = addr; cpuReqWdata = wd;
    @(negedge clk);
    cpuReqValid = 1'b0;
    chk(cpuReqReady == 1'b0, "R8 ready low while busy", 32'(cpuReqReady), 32'd0);
    n = 0;
    while (!cpuRspValid && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk(cpuRspValid == 1'b1, "R9 response arrives", 32'(cpuRspValid), 32'd1);
    rd = cpuRspData; er = cpuRspErr;
    @(negedge clk);
    chk(cpuRspValid == 1'b0, "R9 response one cycle", 32'(cpuRspValid), 32'd0);
    nRd = rdCount - r0; nWr = wrCount - w0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, exp, w;
    logic er;
    int nRd, nWr;
    for (int i = 0; i < WORDS; i++) refMem[i] = initWord(i);
    repeat (3) @(negedge clk);
    chk(cpuReqReady == 1'b1, "R10 reset ready", 32'(cpuReqReady), 32'd1);
    chk(cpuRspValid == 1'b0, "R10 reset rspValid", 32'(cpuRspValid), 32'd0);
    chk(memReqValid == 1'b0, "R10 reset memReqValid", 32'(memReqValid), 32'd0);
    rstN = 1'b1;

    // R2 / R3 byte loads, all addresses, discarded high bits varied (R1)
    for (int a = 0; a < 4 * WORDS; a++) begin
      for (int s = 0; s < 2; s++) begin
        logic [7:0] b;
        logic [ADDR_W-1:0] ad;
        ad = ADDR_W'(a) | ADDR_W'(((a + s) % 4) << 6);
        runReq(1'b0, 1'b1, s[0], ad, 32'h0, rd, er, nRd, nWr);
        b = 8'(refMem[a / 4] >> (8 * (a % 4)));
        exp = (s == 1) ? {{24{b[7]}}, b} : {24'h0, b};
        if (s == 1) chk(rd === exp, "R3 signed byte load", rd, exp);
        else        chk(rd === exp, "R2 unsigned byte load", rd, exp);
        chk(nRd == 1 && nWr == 0, "R2 byte load one read", 32'(nRd * 16 + nWr), 32'h10);
        chk(er == 1'b0, "R9 no error on byte load", 32'(er), 32'd0);
      end
    end

    // R6 word loads with rotation, R1 aliasing
    for (int a = 0; a < 4 * WORDS; a++) begin
      logic [ADDR_W-1:0] ad;
      int o;
      ad = ADDR_W'(a) | ADDR_W'((3 - (a % 4)) << 6);
      o = a % 4;
      runReq(1'b0, 1'b0, 1'b0, ad, 32'h0, rd, er, nRd, nWr);
      w = refMem[a / 4];
      exp = (o == 0) ? w : ((w >> (8 * o)) | (w << (32 - 8 * o)));
      chk(rd === exp, "R6 rotated word load", rd, exp);
      chk(nRd == 1 && nWr == 0, "R6 word load one read", 32'(nRd * 16 + nWr), 32'h10);
    end

    // R4 byte stores read-modify-write
    for (int a = 0; a < 4 * WORDS; a++) begin
      logic [ADDR_W-1:0] ad;
      logic [7:0] nb;
      int wi, o;
      ad = ADDR_W'(a) | ADDR_W'((a % 3) << 6);
      nb = 8'(a * 11 + 3);
      wi = a / 4; o = a % 4;
      runReq(1'b1, 1'b1, 1'b0, ad, {24'hABCDEF, nb}, rd, er, nRd, nWr);
      refMem[wi] = (refMem[wi] & ~(32'hFF << (8 * o))) | (32'(nb) << (8 * o));
      chk(nRd == 1 && nWr == 1, "R4 byte store one read one write", 32'(nRd * 16 + nWr), 32'h11);
      chk(memArr[wi] === refMem[wi], "R4 merged word", memArr[wi], refMem[wi]);
      chk(memArr[(wi + 1) % WORDS] === refMem[(wi + 1) % WORDS], "R4 neighbour word kept",
          memArr[(wi + 1) % WORDS], refMem[(wi + 1) % WORDS]);
      chk(rd === 32'h0 && er == 1'b0, "R9 store response data zero", rd, 32'h0);
    end

    // R5 aligned word stores with high bits set (R1)
    for (int wi = 0; wi < WORDS; wi++) begin
      logic [31:0] d;
      d = 32'h5A00_0000 ^ (32'(wi) * 32'h0103_0507);
      runReq(1'b1, 1'b0, 1'b0, ADDR_W'((wi << 2) | 8'h80), d, rd, er, nRd, nWr);
      refMem[wi] = d;
      chk(nRd == 0 && nWr == 1, "R5 word store one write", 32'(nRd * 16 + nWr), 32'h01);
      chk(memArr[wi] === d, "R5 word stored", memArr[wi], d);
      chk(er == 1'b0, "R9 no error on aligned store", 32'(er), 32'd0);
    end

    // R7 misaligned word stores refused
    for (int wi = 0; wi < WORDS; wi += 5) begin
      for (int o = 1; o < 4; o++) begin
        runReq(1'b1, 1'b0, 1'b0, ADDR_W'((wi << 2) + o), 32'hDEAD_BEEF, rd, er, nRd, nWr);
        chk(er == 1'b1, "R7 error flag", 32'(er), 32'd1);
        chk(nRd == 0 && nWr == 0, "R7 no memory access", 32'(nRd * 16 + nWr), 32'h0);
        chk(memArr[wi] === refMem[wi], "R7 memory unchanged", memArr[wi], refMem[wi]);
      end
    end

    // final readback through the normal port
    for (int wi = 0; wi < WORDS; wi++) begin
      runReq(1'b0, 1'b0, 1'b0, ADDR_W'(wi << 2), 32'h0, rd, er, nRd, nWr);
      chk(rd === refMem[wi], "R6 aligned readback", rd, refMem[wi]);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule